// File: doc/BRIEF.md
# Serial Register Programming Port

This block lets an external host read and write a small bank of 8-bit configuration registers over three wires: a serial data input, an active-low strobe that acts as the shift clock, and a serial data output for read returns. The strobe and data input are brought into the system clock domain through two-flop synchronisers. Each strobe pulse is then classified from the data-input level seen at its falling edge and at its rising edge.

A transaction opens with a start pulse. Twelve address bits follow, least significant first. Then comes one command bit, and finally eight data bits, least significant first. No acknowledge bits are inserted anywhere in the frame. A write becomes visible only after the host sends two further strobe pulses beyond the last data bit. On a read, the addressed register is shifted out on the data output. An abort pulse may be sent at any time to cancel the transaction in progress.

Top module: `ser_cfg_port`

## Requirements
- R1: A frame is, in order: a start pulse, 12 address bits, 1 command bit, and 8 data bits. The transaction state changes only on a strobe rising edge. No acknowledge slot exists.
- R2: Address bits are taken least significant first. Address bits [5:0] select one of 64 entries, and the upper address bits must be zero for the entry to be implemented.
- R3: Data bits travel least significant first, both when written and when read back.
- R4: A pulse whose data input is 1 at the strobe falling edge and 0 at the rising edge is a start. A start restarts address collection even in the middle of a frame.
- R5: A pulse whose data input is 0 at the falling edge and 1 at the rising edge is an abort. An abort returns the port to idle and discards the partial frame, so no register changes.
- R6: A command bit of 1 selects a write and a command bit of 0 selects a read.
- R7: A write commits at the rising edge of the second extra strobe after the eighth data bit. A frame cut short before that point by an abort or a start leaves the register unchanged.
- R8: On a read, the data output presents D0 after the command bit's rising edge. It advances by one bit at each later rising edge, and it returns to 0 after the eighth read strobe.
- R9: The data output is 0 whenever no read is in progress.
- R10: Reads of unimplemented addresses return 0x00, and writes to them change no register.
- R11: After reset, every register holds 0x00, the port is idle and the data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_n_i | input | 1 | Active-low shift strobe from the host |
| sdi_i | input | 1 | Serial data, address and command from the host |
| sdo_o | output | 1 | Serial read data returned to the host |

## Verification
A bit counter that slips makes every later field land in the wrong place. That shows up on the next readback as a byte taken from a neighbouring address, or as rotated data. A wrong pulse class leaves stale or zero data, or commits a write that should have been cancelled, and this is visible on the first read after the faulty frame. A read state that lingers drives non-zero bits on the data output during idle or write strobes. These are sampled inside every strobe, so the fault shows within one strobe period.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_CMD   = 3'd2,
        ST_WDATA = 3'd3,
        ST_WTAIL = 3'd4,
        ST_RDATA = 3'd5
    } cfg_state_e;

    typedef struct packed {
        logic stb_prev;
        logic lead_val;
    } pulse_regs_t;

endpackage

// File: rtl/ser_cfg_sync.sv
module ser_cfg_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
            else        chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/ser_cfg_pulse.sv
module ser_cfg_pulse
    import ser_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_s,
    input  logic sdi_s,
    output logic bit_tick,
    output logic bit_val,
    output logic start_p,
    output logic abort_p
);

    pulse_regs_t r_d, r_q;
    logic lead, trail;

    always_comb begin
        r_d   = r_q;
        lead  = r_q.stb_prev & ~strobe_s;
        trail = ~r_q.stb_prev & strobe_s;
        r_d.stb_prev = strobe_s;
        if (lead) r_d.lead_val = sdi_s;
        start_p  = trail &  r_q.lead_val & ~sdi_s;
        abort_p  = trail & ~r_q.lead_val &  sdi_s;
        bit_tick = trail & (r_q.lead_val == sdi_s);
        bit_val  = sdi_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{stb_prev: 1'b1, lead_val: 1'b0};
        else        r_q <= r_d;
    end

endmodule

// File: rtl/ser_cfg_bank.sv
module ser_cfg_bank #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              hit;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        hit   = (int'(addr) < DEPTH);
        idx   = addr[IDX_W-1:0];
        rdata = hit ? mem_q[idx] : '0;
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en && hit) mem_d[idx] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

endmodule

// File: rtl/ser_cfg_port.sv
module ser_cfg_port
    import ser_cfg_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int DATA_W       = 8,
    parameter int DEPTH        = 64,
    parameter int TAIL_STROBES = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n_i,
    input  logic sdi_i,
    output logic sdo_o
);

    localparam int CNT_MAX = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        cfg_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] shreg;
        logic              sdo;
    } fsm_t;

    fsm_t              f_d, f_q;
    logic [1:0]        sync_v;
    logic              bit_tick, bit_val, start_p, abort_p;
    logic              wr_en;
    logic [DATA_W-1:0] rdata;
    cfg_state_e        state_q;

    ser_cfg_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b10)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({strobe_n_i, sdi_i}),
        .sync_o (sync_v)
    );

    ser_cfg_pulse u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe_s(sync_v[1]),
        .sdi_s   (sync_v[0]),
        .bit_tick(bit_tick),
        .bit_val (bit_val),
        .start_p (start_p),
        .abort_p (abort_p)
    );

    ser_cfg_bank #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .addr (f_q.addr),
        .wdata(f_q.shreg),
        .rdata(rdata)
    );

    always_comb begin
        f_d   = f_q;
        wr_en = 1'b0;
        if (abort_p) begin
            f_d.state = ST_IDLE;
            f_d.cnt   = '0;
            f_d.sdo   = 1'b0;
        end else if (start_p) begin
            f_d.state = ST_ADDR;
            f_d.cnt   = '0;
            f_d.addr  = '0;
            f_d.sdo   = 1'b0;
        end else if (bit_tick) begin
            unique case (f_q.state)
                ST_ADDR: begin
                    f_d.addr = {bit_val, f_q.addr[ADDR_W-1:1]};
                    if (f_q.cnt == CNT_W'(ADDR_W - 1)) begin
                        f_d.state = ST_CMD;
                        f_d.cnt   = '0;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                ST_CMD: begin
                    f_d.cnt = '0;
                    if (bit_val) begin
                        f_d.state = ST_WDATA;
                    end else begin
                        f_d.state = ST_RDATA;
                        f_d.shreg = rdata;
                        f_d.sdo   = rdata[0];
                    end
                end
                ST_WDATA: begin
                    f_d.shreg = {bit_val, f_q.shreg[DATA_W-1:1]};
                    if (f_q.cnt == CNT_W'(DATA_W - 1)) begin
                        f_d.state = ST_WTAIL;
                        f_d.cnt   = '0;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                ST_WTAIL: begin
                    if (f_q.cnt == CNT_W'(TAIL_STROBES - 1)) begin
                        wr_en     = 1'b1;
                        f_d.state = ST_IDLE;
                        f_d.cnt   = '0;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                ST_RDATA: begin
                    if (f_q.cnt == CNT_W'(DATA_W - 1)) begin
                        f_d.state = ST_IDLE;
                        f_d.cnt   = '0;
                        f_d.sdo   = 1'b0;
                    end else begin
                        f_d.shreg = f_q.shreg >> 1;
                        f_d.sdo   = f_q.shreg[1];
                        f_d.cnt   = f_q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{state: ST_IDLE, cnt: '0, addr: '0, shreg: '0, sdo: 1'b0};
        else        f_q <= f_d;
    end

    assign sdo_o   = f_q.sdo;
    assign state_q = f_q.state;

endmodule

// File: rtl/ser_cfg_checker.sv
module ser_cfg_checker
    import ser_cfg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sdo_o,
    input cfg_state_e state,
    input logic       bit_tick,
    input logic       start_p,
    input logic       abort_p,
    input logic       wr_en
);

    AST_STATE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_tick || start_p || abort_p) |=> $stable(state)); // R1

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> state == ST_ADDR); // R4

    AST_PULSE_CLASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bit_tick, start_p, abort_p})); // R4

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_p |=> (state == ST_IDLE) && !sdo_o); // R5

    AST_COMMIT_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> state == ST_IDLE); // R7

    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RDATA) |-> !sdo_o); // R9

endmodule

bind ser_cfg_port ser_cfg_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sdo_o   (sdo_o),
    .state   (state_q),
    .bit_tick(bit_tick),
    .start_p (start_p),
    .abort_p (abort_p),
    .wr_en   (wr_en)
);

// File: tb/ser_cfg_port_test.sv
module ser_cfg_port_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe_n = 1'b1;
    logic sdi = 1'b0;
    logic sdo;

    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    logic [7:0] mdl [64];

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] got_q[$];

    always #10 clk = ~clk;

    ser_cfg_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_n_i(strobe_n),
        .sdi_i     (sdi),
        .sdo_o     (sdo)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // one strobe pulse: data level at falling edge a, at rising edge b
    task automatic pulse(input logic a, input logic b, output logic seen);
        @(negedge clk) sdi = a;
        repeat (2) @(negedge clk);
        strobe_n = 1'b0;
        @(negedge clk) seen = sdo;
        repeat (2) @(negedge clk);
        sdi = b;
        repeat (3) @(negedge clk);
        strobe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_start();
        logic s;
        pulse(1'b1, 1'b0, s);
    endtask

    task automatic send_abort();
        logic s;
        pulse(1'b0, 1'b1, s);
    endtask

    task automatic send_bit(input logic b, input string tag);
        logic s;
        pulse(b, b, s);
        chk(s == 1'b0, tag, s, 0);
    endtask

    task automatic send_hdr(input logic [11:0] addr, input logic wr);
        send_start();
        for (int i = 0; i < 12; i++) send_bit(addr[i], "R9 sdo during address");
        send_bit(wr, "R9 sdo during command");
    endtask

    task automatic write_reg(input logic [11:0] addr, input logic [7:0] data, input int tail);
        logic s;
        send_hdr(addr, 1'b1);
        for (int i = 0; i < 8; i++) send_bit(data[i], "R9 sdo during write data");
        for (int i = 0; i < tail; i++) pulse(1'b0, 1'b0, s);
        if (tail >= 2 && addr < 12'd64) mdl[addr[5:0]] = data;
    endtask

    task automatic read_reg(input logic [11:0] addr, input string tag);
        logic [7:0] got;
        logic       s;
        exp_t       e;
        send_hdr(addr, 1'b0);
        for (int i = 0; i < 8; i++) begin
            pulse(1'b0, 1'b0, s);
            got[i] = s;
        end
        e.val = (addr < 12'd64) ? mdl[addr[5:0]] : 8'h00;
        e.tag = tag;
        exp_q.push_back(e);
        got_q.push_back(got);
        repeat (2) @(negedge clk);
        chk(sdo == 1'b0, "R8 sdo low after eighth read strobe", sdo, 0);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            exp_t       e;
            logic [7:0] g;
            wait (got_q.size() != 0);
            e = exp_q.pop_front();
            g = got_q.pop_front();
            chk(g === e.val, e.tag, g, e.val);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic s;
        for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        chk(sdo == 1'b0, "R11 sdo after reset", sdo, 0);
        read_reg(12'd0, "R11 reg0 reset value");
        read_reg(12'd63, "R11 reg63 reset value");

        // basic write then read, several patterns (R1 R3 R6)
        write_reg(12'd0, 8'hA5, 2);
        write_reg(12'd5, 8'h3C, 2);
        write_reg(12'd63, 8'h81, 2);
        write_reg(12'd1, 8'h01, 2);
        read_reg(12'd0, "R1 R6 read back reg0");
        read_reg(12'd5, "R2 read back reg5");
        read_reg(12'd63, "R2 read back reg63");
        read_reg(12'd1, "R3 LSB first value 0x01");

        // unimplemented addresses (R10, R2 upper bits)
        write_reg(12'd64, 8'hFF, 2);
        write_reg(12'hFC5, 8'h77, 2);
        read_reg(12'd0, "R10 write to 0x040 did not alias reg0");
        read_reg(12'd5, "R10 write to 0xFC5 did not alias reg5");
        read_reg(12'd64, "R10 unimplemented read 0x040");
        read_reg(12'hFFF, "R10 unimplemented read 0xFFF");

        // abort in address phase, then abort in data phase (R5)
        send_start();
        for (int i = 0; i < 5; i++) send_bit(1'b1, "R9 sdo during aborted address");
        send_abort();
        send_hdr(12'd5, 1'b1);
        for (int i = 0; i < 4; i++) send_bit(1'b1, "R9 sdo during aborted data");
        send_abort();
        read_reg(12'd5, "R5 aborted frames left reg5");

        // abort after one extra strobe: no commit (R7)
        send_hdr(12'd63, 1'b1);
        for (int i = 0; i < 8; i++) send_bit(1'b0, "R9 sdo during write data");
        pulse(1'b0, 1'b0, s);
        send_abort();
        read_reg(12'd63, "R7 abort in tail keeps reg63");

        // only one tail strobe then a new start: no commit (R7)
        write_reg(12'd0, 8'h5A, 1);
        read_reg(12'd0, "R7 single tail strobe keeps reg0");

        // start in the middle of an address restarts collection (R4)
        send_start();
        for (int i = 0; i < 7; i++) send_bit(1'b1, "R9 sdo during partial address");
        write_reg(12'd9, 8'hC3, 2);
        read_reg(12'd9, "R4 restarted frame wrote reg9");
        read_reg(12'd63, "R4 partial frame did not touch reg63");

        // start during a read cuts it short, sdo back low (R4 R9)
        send_hdr(12'd0, 1'b0);
        pulse(1'b0, 1'b0, s);
        chk(s == mdl[0][0], "R8 first read bit is D0", s, mdl[0][0]);
        send_start();
        repeat (2) @(negedge clk);
        chk(sdo == 1'b0, "R4 R9 start ends read, sdo low", sdo, 0);
        send_abort();

        write_reg(12'd9, 8'h00, 2);
        read_reg(12'd9, "R3 overwrite to zero");

        wait (got_q.size() == 0);
        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule